// File: doc/BRIEF.md
# Inter-processor doorbell interrupt block

This block sits beside one processor in a multi-agent system and handles doorbell interrupts between that processor and up to eleven remote agents. Software rings a remote agent by writing a 1 to that agent's channel bit in the ring register, which produces a one-cycle pulse on that channel's outgoing doorbell line. Incoming doorbells from remote agents are latched into a pending register. Software acknowledges a doorbell by writing 1 to its pending bit.

A mask, which software can change only through separate unmask and mask-set registers, decides which pending bits drive the single interrupt output. Each channel's latched pending bit is also driven out, so a remote agent can see that its doorbell has not been acknowledged. A read-only acknowledge register shows the level of the acknowledge inputs returned by the remote agents.

The channels use a sparse map in a 32-bit word: bit 0, bits 8 and 9, bits 16 to 19, and bits 24 to 27. This gives a valid mask of 0x0F0F0301. Accesses are aligned 32-bit words on a simple bus. The bus has a one-cycle write strobe and registered read data that arrives one cycle after the read strobe.

Top module: `ipi_regblock`

## Requirements
- R1: Only the channel bits in 0x0F0F0301 exist. Every other bit reads 0, ignores writes, and is never driven on any output.
- R2: Writing the ring register at offset 0x00 drives `ring_o` with the written valid bits for exactly the one cycle after the write edge. `ring_o` then returns to 0, and a read of offset 0x00 returns 0.
- R3: The acknowledge register at offset 0x04 is read-only. Each of its valid bits holds the level that `ack_i` had at the previous clock edge.
- R4: A pending bit at offset 0x10 sets on any clock edge at which its `ring_i` bit is high. Writing 1 to the bit clears it. Writing 0 leaves it unchanged.
- R5: The mask register at offset 0x14 is read-only. It resets to 0x0F0F0301, so every channel starts masked.
- R6: Writing 1s to offset 0x18 clears those mask bits, and writing 1s to offset 0x1C sets them. Both offsets read 0.
- R7: `irq_o` is high exactly when some pending bit is set while its mask bit is clear. It follows the registered pending and mask state in the same cycle.
- R8: `pend_o` mirrors the pending register bit for bit.
- R9: When an incoming doorbell and a write-1-to-clear hit the same pending bit at one edge, the bit stays set.
- R10: `bus_rdata_o` is registered. It holds the addressed value in the cycle after a read strobe and 0 otherwise. Unmapped or misaligned offsets read 0 and ignore writes.
- R11: During reset the pending, ring and acknowledge state read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| ring_i | input | 32 | Incoming doorbells from remote agents |
| ack_i | input | 32 | Acknowledge levels from remote agents |
| ring_o | output | 32 | Outgoing doorbell pulses, one per channel |
| pend_o | output | 32 | Per-channel copy of latched pending bits |
| irq_o | output | 1 | Interrupt to the local processor |

## Verification
Every register in this block updates at the clock edge that captures the write strobe or the doorbell. The bench therefore drives on a falling edge and samples `ring_o`, `pend_o` and `irq_o` on the next falling edge, one cycle later. It checks the ring pulse again one cycle after that to confirm the pulse has cleared. The acknowledge register needs one edge to capture `ack_i` and a second edge for the read, so its value is read two cycles after the input changes. Each read pushes its expected word into a queue when the strobe is driven, and a monitor pops the queue on the falling edge after the capture edge, when the registered read data is valid.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned ADDR_W = 8;
  parameter logic [DATA_W-1:0] CHAN_MASK = 32'h0F0F_0301;

  localparam int unsigned NUM_REGS = 6;

  typedef enum logic [2:0] {
    REG_RING  = 3'd0,
    REG_ACK   = 3'd1,
    REG_PEND  = 3'd2,
    REG_MASK  = 3'd3,
    REG_UNMSK = 3'd4,
    REG_MSET  = 3'd5
  } reg_id_e;

  function automatic logic [ADDR_W-1:0] reg_offset(input int unsigned idx);
    case (idx)
      0: reg_offset = ADDR_W'(8'h00);
      1: reg_offset = ADDR_W'(8'h04);
      2: reg_offset = ADDR_W'(8'h10);
      3: reg_offset = ADDR_W'(8'h14);
      4: reg_offset = ADDR_W'(8'h18);
      default: reg_offset = ADDR_W'(8'h1C);
    endcase
  endfunction
endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode
  import ipi_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  output logic [NUM_REGS-1:0] hit_o,
  output logic [NUM_REGS-1:0] we_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit_o[g] = (addr_i == reg_offset(g));
    assign we_o[g]  = wr_i & hit_o[g];
  end
endmodule

// File: rtl/ipi_chan_bank.sv
module ipi_chan_bank
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_we_i,
  input  logic              pend_we_i,
  input  logic              unmsk_we_i,
  input  logic              mset_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ring_i,
  input  logic [DATA_W-1:0] ack_i,
  output logic [DATA_W-1:0] ring_q_o,
  output logic [DATA_W-1:0] pend_q_o,
  output logic [DATA_W-1:0] mask_q_o,
  output logic [DATA_W-1:0] ack_q_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (CHAN_MASK[b]) begin : g_chan
      logic ring_q, pend_q, mask_q, ack_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ring_q <= 1'b0;
          pend_q <= 1'b0;
          mask_q <= 1'b1;
          ack_q  <= 1'b0;
        end else begin
          ring_q <= ring_we_i & wdata_i[b];
          // incoming doorbell beats a same-cycle clear
          pend_q <= ring_i[b] | (pend_q & ~(pend_we_i & wdata_i[b]));
          if (unmsk_we_i && wdata_i[b]) mask_q <= 1'b0;
          else if (mset_we_i && wdata_i[b]) mask_q <= 1'b1;
          ack_q  <= ack_i[b];
        end
      end
      assign ring_q_o[b] = ring_q;
      assign pend_q_o[b] = pend_q;
      assign mask_q_o[b] = mask_q;
      assign ack_q_o[b]  = ack_q;
    end else begin : g_rsvd
      assign ring_q_o[b] = 1'b0;
      assign pend_q_o[b] = 1'b0;
      assign mask_q_o[b] = 1'b0;
      assign ack_q_o[b]  = 1'b0;
    end
  end
endmodule

// File: rtl/ipi_irq_merge.sv
module ipi_irq_merge
  import ipi_pkg::*;
(
  input  logic [DATA_W-1:0] pend_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              irq_o
);
  assign irq_o = |(pend_i & ~mask_i);
endmodule

// File: rtl/ipi_regblock.sv
module ipi_regblock
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] ring_i,
  input  logic [DATA_W-1:0] ack_i,
  output logic [DATA_W-1:0] ring_o,
  output logic [DATA_W-1:0] pend_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] hit, we;
  logic [DATA_W-1:0]   ring_q, pend_q, mask_q, ack_q, rd_mux, rdata_q;

  ipi_bus_decode u_dec (
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .hit_o  (hit),
    .we_o   (we)
  );

  ipi_chan_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ring_we_i  (we[REG_RING]),
    .pend_we_i  (we[REG_PEND]),
    .unmsk_we_i (we[REG_UNMSK]),
    .mset_we_i  (we[REG_MSET]),
    .wdata_i    (bus_wdata_i),
    .ring_i     (ring_i),
    .ack_i      (ack_i),
    .ring_q_o   (ring_q),
    .pend_q_o   (pend_q),
    .mask_q_o   (mask_q),
    .ack_q_o    (ack_q)
  );

  ipi_irq_merge u_irq (
    .pend_i (pend_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  // ring, unmask and mask-set offsets read back as zero
  always_comb begin
    rd_mux = '0;
    if (hit[REG_ACK])  rd_mux = ack_q;
    if (hit[REG_PEND]) rd_mux = pend_q;
    if (hit[REG_MASK]) rd_mux = mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= bus_rd_i ? rd_mux : '0;
  end

  assign bus_rdata_o = rdata_q;
  assign ring_o      = ring_q;
  assign pend_o      = pend_q;
endmodule

// File: rtl/ipi_regblock_chk.sv
module ipi_regblock_chk
  import ipi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [DATA_W-1:0] ring_i,
  input logic [DATA_W-1:0] ring_o,
  input logic [DATA_W-1:0] pend_o,
  input logic              irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_no_rsvd_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ring_o | pend_o | bus_rdata_o) & ~CHAN_MASK) == '0);

  a_r2_ring_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && ring_o != '0) |-> ($past(bus_wr_i) && $past(bus_addr_i) == 8'h00
                                  && ring_o == ($past(bus_wdata_i) & CHAN_MASK)));

  a_r9_doorbell_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((pend_o & $past(ring_i) & CHAN_MASK) == ($past(ring_i) & CHAN_MASK)));

  a_r7_irq_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_o != '0));

  a_r10_rdata_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(bus_rd_i)) |-> (bus_rdata_o == '0));

  a_r4_pend_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ring_i) == '0) |-> ((pend_o & ~$past(pend_o)) == '0));
endmodule

bind ipi_regblock ipi_regblock_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .ring_i      (ring_i),
  .ring_o      (ring_o),
  .pend_o      (pend_o),
  .irq_o       (irq_o)
);

// File: tb/sim_ipi_regblock.sv
module sim_ipi_regblock;
  localparam logic [31:0] VM = 32'h0F0F_0301;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata, ring_in = '0, ack_in = '0, ring_out, pend_out;
  logic        irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_regblock u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .ring_i(ring_in), .ack_i(ack_in), .ring_o(ring_out), .pend_o(pend_out),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  // monitor: registered read data is due one edge after the strobe
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R10 unexpected read", rdata, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 irq in reset", {31'b0, irq}, 32'h0);
    chk("R11 pend in reset", pend_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    bus_rd(8'h14, VM, "R5 mask reset");
    bus_rd(8'h10, 32'h0, "R11 pend after reset");

    // R2 ring pulse, reserved bits dropped (R1)
    bus_wr(8'h00, 32'hFFFF_FFFF);
    chk("R2 ring pulse", ring_out, VM);
    @(negedge clk);
    chk("R2 ring cleared", ring_out, 32'h0);
    bus_wr(8'h00, 32'h0000_0200);
    chk("R2 ring single", ring_out, 32'h0000_0200);
    bus_rd(8'h00, 32'h0, "R2 ring reads zero");

    // R3 acknowledge levels
    ack_in = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_rd(8'h04, VM, "R3 ack all (R1 rsvd)");
    ack_in = 32'h0100_0001;
    @(negedge clk);
    bus_rd(8'h04, 32'h0100_0001, "R3 ack pattern");
    bus_wr(8'h04, 32'h0);
    bus_rd(8'h04, 32'h0100_0001, "R3 ack read-only");

    // R4 doorbell latch, masked
    ring_in = 32'h8000_0100;
    @(negedge clk);
    ring_in = '0;
    chk("R8 pend mirror", pend_out, 32'h0000_0100);
    chk("R7 masked no irq", {31'b0, irq}, 32'h0);
    bus_rd(8'h10, 32'h0000_0100, "R4 pend latched");
    bus_wr(8'h10, 32'h0);
    chk("R4 write0 no effect", pend_out, 32'h0000_0100);

    // R6 unmask / mask-set, R7 irq
    bus_wr(8'h18, 32'h0000_0100);
    chk("R7 irq after unmask", {31'b0, irq}, 32'h1);
    bus_rd(8'h14, 32'h0F0F_0201, "R6 mask after unmask");
    bus_rd(8'h18, 32'h0, "R6 unmask reads zero");
    bus_wr(8'h1C, 32'hFFFF_FFFF);
    chk("R7 irq after mask-set", {31'b0, irq}, 32'h0);
    bus_rd(8'h14, VM, "R6 mask after set");
    bus_rd(8'h1C, 32'h0, "R6 mask-set reads zero");
    bus_wr(8'h14, 32'h0);
    bus_rd(8'h14, VM, "R5 mask read-only");
    bus_wr(8'h18, 32'h0000_0100);
    bus_wr(8'h10, 32'h0000_0100);
    chk("R4 w1c clears", pend_out, 32'h0);
    chk("R7 irq drops on clear", {31'b0, irq}, 32'h0);

    // R9 set wins
    addr = 8'h10; wdata = 32'h0001_0000; wr = 1'b1; ring_in = 32'h0001_0000;
    @(negedge clk);
    wr = 1'b0; wdata = '0; ring_in = '0;
    chk("R9 set wins", pend_out, 32'h0001_0000);
    bus_wr(8'h10, 32'h0001_0000);
    chk("R9 later clear", pend_out, 32'h0);

    // R10 unmapped / misaligned
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h15, 32'hFFFF_FFFF);
    bus_rd(8'h08, 32'h0, "R10 unmapped read");
    bus_rd(8'h11, 32'h0, "R10 misaligned read");
    bus_rd(8'h14, 32'h0F0F_0201, "R10 writes ignored");
    chk("R10 no ring", ring_out, 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule